// File: doc/BRIEF.md
# Fuse ROM Read Controller

This block lets a host CPU read a one-time-programmable fuse store through a small register window. Software writes a control word carrying a byte start address, a byte count minus one and a read-enable bit. The controller then walks the fuse array's word address and read strobe with bus-clock timing taken from a configuration register. It gathers up to 32 bytes, publishes them together in eight 32-bit data words and raises a done flag. An optional level interrupt follows that flag.

The fuse store holds 1024 bytes. It is reached as 512 sixteen-bit words through a 9-bit word address. Each strobed access returns one word. The fuse-array model used for testing lives in the bench.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `fuse_strobe` is 0.
- R2: Word offsets are control 0x0, configuration 0x4, status 0x8, and data word n at 0xC+4n. Control holds start address [30:21], length-minus-one [20:16], program-enable bit 15, write-enable bit 1 and read-enable bit 0, and reads 0 elsewhere. Configuration keeps bit 31 (interrupt enable), [23:20] (read adjust), [19:16] (read strobe), [15:12] and [11:0], and reads 0 in bits [30:24]. Status bit 1 (write done) always reads 0.
- R3: Each fuse access lasts adj+5+str clock cycles. The strobe is low for the first adj+1 cycles and high for the remaining str+4. It first goes high adj+1 cycles after the clock edge that takes the starting control write.
- R4: A transfer makes len/2+1 accesses, rounded down, to consecutive fuse words. It starts at word {addr[9:5], 4'b0}, so address bits [4:0] are ignored. The word address stays fixed within an access.
- R5: The done flag (status bit 0) is cleared by the starting write and becomes 1 exactly n*(adj+5+str) cycles after that write's edge, where n is the access count. At that same edge, read-enable reads back 0.
- R6: Data bytes are packed little-endian. Window byte i sits in data word i/4, bits [8*(i%4)+7 : 8*(i%4)]. Byte i is fuse byte base+i, and a fuse word's low byte is the lower address. Bytes with i greater than len read 0.
- R7: A control write while a transfer is in progress changes nothing and starts nothing. The data words keep their previous contents until the running transfer completes.
- R8: A control write with write-enable or program-enable set and read-enable clear stores those bits. It changes no status bit and issues no strobe.
- R9: `irq` equals interrupt-enable AND done. Writing 1 to status bit 0 clears done, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| fuse_addr | output | 9 | Fuse word address |
| fuse_strobe | output | 1 | Fuse read strobe |
| fuse_rdata | input | 16 | Fuse word returned by the array |
| irq | output | 1 | Level interrupt |

## Verification
The main sweep covers every pair of read-adjust and read-strobe values, 256 transfers in all. The length and start address change with each pair, so single-access, full-window and odd and even byte counts all occur, and most start addresses are misaligned. The bench checks the strobe level and word address every cycle of every transfer. This separates an off-by-one in the setup phase from one in the strobe phase or the access count, and the varied lengths expose a wrong zero-fill boundary or byte order. Directed sequences then cover a control write during a transfer, write- or program-enable without read-enable, and the clear and interrupt behaviour of the done flag.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  // register word indices (byte offset / 4)
  localparam int WI_CTRL  = 0;
  localparam int WI_CFG   = 1;
  localparam int WI_STAT  = 2;
  localparam int WI_DATA0 = 3;

  // control field positions
  localparam int CT_ADDR_LSB = 21;
  localparam int CT_LEN_LSB  = 16;
  localparam int CT_PG_BIT   = 15;
  localparam int CT_WR_BIT   = 1;
  localparam int CT_RD_BIT   = 0;
  localparam int CT_ADDR_W   = 10;
  localparam int CT_LEN_W    = 5;

  // configuration fields
  localparam int          CF_IRQ_BIT  = 31;
  localparam int          CF_RADJ_LSB = 20;
  localparam int          CF_RSTR_LSB = 16;
  localparam logic [31:0] CF_MASK     = 32'h80FF_FFFF;

  localparam int ST_RDONE_BIT = 0;

  typedef struct packed {
    logic [CT_ADDR_W-1:0] addr;
    logic [CT_LEN_W-1:0]  len;
    logic                 pg;
    logic                 wr;
    logic                 rd;
  } ctrl_t;

endpackage

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
  import fuse_rd_pkg::*;
#(
  parameter int WIN_WORDS = 8,
  parameter int BUS_AW    = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wen,
  input  logic [BUS_AW-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic                    busy,
  input  logic                    done_pulse,
  input  logic [WIN_WORDS*32-1:0] window,
  output logic                    start,
  output logic [CT_ADDR_W-1:0]    req_addr,
  output logic [CT_LEN_W-1:0]     req_len,
  output logic [CT_LEN_W-1:0]     cur_len,
  output logic [3:0]              rd_adj,
  output logic [3:0]              rd_str,
  output logic                    irq
);

  localparam int WI_W = BUS_AW - 2;

  logic [WI_W-1:0] wi;
  logic            wr_ctrl, wr_cfg, wr_stat;
  ctrl_t           ctrl_q, ctrl_d, ctrl_wr;
  logic [31:0]     cfg_q, cfg_d;
  logic            done_q, done_d;
  logic            unused_addr;

  assign wi          = bus_addr[BUS_AW-1:2];
  assign unused_addr = ^bus_addr[1:0];
  assign wr_ctrl     = bus_wen && (wi == WI_W'(WI_CTRL));
  assign wr_cfg      = bus_wen && (wi == WI_W'(WI_CFG));
  assign wr_stat     = bus_wen && (wi == WI_W'(WI_STAT));
  assign start       = wr_ctrl && !busy && bus_wdata[CT_RD_BIT];

  always_comb begin
    ctrl_wr.addr = bus_wdata[CT_ADDR_LSB +: CT_ADDR_W];
    ctrl_wr.len  = bus_wdata[CT_LEN_LSB +: CT_LEN_W];
    ctrl_wr.pg   = bus_wdata[CT_PG_BIT];
    ctrl_wr.wr   = bus_wdata[CT_WR_BIT];
    ctrl_wr.rd   = bus_wdata[CT_RD_BIT];
  end

  // next-state
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl && !busy) ctrl_d = ctrl_wr;
    if (done_pulse)       ctrl_d.rd = 1'b0;

    cfg_d = cfg_q;
    if (wr_cfg) cfg_d = bus_wdata & CF_MASK;

    done_d = done_q;
    if (wr_stat && bus_wdata[ST_RDONE_BIT]) done_d = 1'b0;
    if (start)                              done_d = 1'b0;
    if (done_pulse)                         done_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cfg_q  <= cfg_d;
      done_q <= done_d;
    end
  end

  assign req_addr = ctrl_d.addr;
  assign req_len  = ctrl_d.len;
  assign cur_len  = ctrl_q.len;
  assign rd_adj   = cfg_q[CF_RADJ_LSB +: 4];
  assign rd_str   = cfg_q[CF_RSTR_LSB +: 4];
  assign irq      = cfg_q[CF_IRQ_BIT] && done_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (wi == WI_W'(WI_CTRL)) begin
      bus_rdata[CT_ADDR_LSB +: CT_ADDR_W] = ctrl_q.addr;
      bus_rdata[CT_LEN_LSB +: CT_LEN_W]   = ctrl_q.len;
      bus_rdata[CT_PG_BIT]                = ctrl_q.pg;
      bus_rdata[CT_WR_BIT]                = ctrl_q.wr;
      bus_rdata[CT_RD_BIT]                = ctrl_q.rd;
    end else if (wi == WI_W'(WI_CFG)) begin
      bus_rdata = cfg_q;
    end else if (wi == WI_W'(WI_STAT)) begin
      bus_rdata[ST_RDONE_BIT] = done_q;
    end else begin
      for (int n = 0; n < WIN_WORDS; n++) begin
        if (wi == WI_W'(WI_DATA0 + n)) bus_rdata = window[32*n +: 32];
      end
    end
  end

  AST_RD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> (!ctrl_q.rd && done_q)); // R5
  AST_BUSY_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl) |=> (ctrl_q.addr == $past(ctrl_q.addr) && ctrl_q.len == $past(ctrl_q.len))); // R7
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_q); // R9

endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq #(
  parameter int FUSE_AW = 9,
  parameter int ACC_MAX = 16,
  localparam int IDX_W  = $clog2(ACC_MAX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FUSE_AW-1:0] base_in,
  input  logic [IDX_W-1:0]   last_in,
  input  logic [3:0]         adj_in,
  input  logic [3:0]         str_in,
  output logic               busy,
  output logic [FUSE_AW-1:0] fuse_addr,
  output logic               fuse_strobe,
  output logic               cap_valid,
  output logic [IDX_W-1:0]   cap_idx,
  output logic               done_pulse
);

  localparam int CYC_W = 6;

  logic               busy_q, busy_d;
  logic [CYC_W-1:0]   cyc_q, cyc_d, last_cyc;
  logic [IDX_W-1:0]   acc_q, acc_d, last_q, last_d;
  logic [3:0]         adj_q, adj_d, str_q, str_d;
  logic [FUSE_AW-1:0] base_q, base_d;
  logic               at_end;

  assign last_cyc = CYC_W'(adj_q) + CYC_W'(str_q) + CYC_W'(4);
  assign at_end   = busy_q && (cyc_q == last_cyc);

  always_comb begin
    busy_d = busy_q;
    cyc_d  = cyc_q;
    acc_d  = acc_q;
    last_d = last_q;
    adj_d  = adj_q;
    str_d  = str_q;
    base_d = base_q;
    if (start) begin
      busy_d = 1'b1;
      cyc_d  = '0;
      acc_d  = '0;
      last_d = last_in;
      adj_d  = adj_in;
      str_d  = str_in;
      base_d = base_in;
    end else if (at_end) begin
      cyc_d = '0;
      if (acc_q == last_q) busy_d = 1'b0;
      else                 acc_d  = acc_q + IDX_W'(1);
    end else if (busy_q) begin
      cyc_d = cyc_q + CYC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cyc_q  <= '0;
      acc_q  <= '0;
      last_q <= '0;
      adj_q  <= '0;
      str_q  <= '0;
      base_q <= '0;
    end else begin
      busy_q <= busy_d;
      cyc_q  <= cyc_d;
      acc_q  <= acc_d;
      last_q <= last_d;
      adj_q  <= adj_d;
      str_q  <= str_d;
      base_q <= base_d;
    end
  end

  assign busy        = busy_q;
  assign fuse_addr   = base_q + FUSE_AW'(acc_q);
  assign fuse_strobe = busy_q && (cyc_q > CYC_W'(adj_q));
  assign cap_valid   = at_end;
  assign cap_idx     = acc_q;
  assign done_pulse  = at_end && (acc_q == last_q);

  AST_SETUP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !fuse_strobe); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_strobe && $past(fuse_strobe)) |-> $stable(fuse_addr)); // R4
  AST_CAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> (cap_idx <= last_q)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !busy_q); // R5

endmodule

// File: rtl/fuse_rd_capture.sv
module fuse_rd_capture #(
  parameter int FUSE_W    = 16,
  parameter int WIN_WORDS = 8,
  localparam int WIN_BYTES = WIN_WORDS * 4,
  localparam int ACC_MAX   = WIN_BYTES / (FUSE_W / 8),
  localparam int IDX_W     = $clog2(ACC_MAX),
  localparam int LEN_W     = $clog2(WIN_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_valid,
  input  logic [IDX_W-1:0]        cap_idx,
  input  logic [FUSE_W-1:0]       fuse_rdata,
  input  logic                    done_pulse,
  input  logic [LEN_W-1:0]        len,
  output logic [WIN_WORDS*32-1:0] window
);

  logic [FUSE_W-1:0]       shadow_q [ACC_MAX];
  logic [WIN_BYTES*8-1:0]  merged;
  logic [WIN_BYTES*8-1:0]  win_d;
  logic [WIN_WORDS*32-1:0] window_q;

  for (genvar k = 0; k < ACC_MAX; k++) begin : g_slot
    logic hit;
    assign hit = cap_valid && (cap_idx == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   shadow_q[k] <= '0;
      else if (hit) shadow_q[k] <= fuse_rdata;
    end
    assign merged[k*FUSE_W +: FUSE_W] = hit ? fuse_rdata : shadow_q[k];
  end

  for (genvar i = 0; i < WIN_BYTES; i++) begin : g_byte
    assign win_d[8*i +: 8] = (len >= LEN_W'(i)) ? merged[8*i +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          window_q <= '0;
    else if (done_pulse) window_q <= win_d;
  end

  assign window = window_q;

  AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |=> $stable(window_q)); // R7

endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
  import fuse_rd_pkg::*;
#(
  parameter int  BYTE_AW   = 10,
  parameter int  FUSE_W    = 16,
  parameter int  WIN_WORDS = 8,
  localparam int BUS_AW    = $clog2((WI_DATA0 + WIN_WORDS) * 4),
  localparam int FUSE_AW   = BYTE_AW - $clog2(FUSE_W / 8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wen,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [FUSE_AW-1:0] fuse_addr,
  output logic               fuse_strobe,
  input  logic [FUSE_W-1:0]  fuse_rdata,
  output logic               irq
);

  localparam int BPF_LG    = $clog2(FUSE_W / 8);
  localparam int WIN_BYTES = WIN_WORDS * 4;
  localparam int WIN_LG    = $clog2(WIN_BYTES);
  localparam int ACC_MAX   = WIN_BYTES / (FUSE_W / 8);
  localparam int IDX_W     = $clog2(ACC_MAX);

  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  logic                    start, busy, done_pulse, cap_valid;
  logic [IDX_W-1:0]        cap_idx;
  logic [CT_ADDR_W-1:0]    req_addr;
  logic [CT_LEN_W-1:0]     req_len, cur_len;
  logic [3:0]              rd_adj, rd_str;
  logic [WIN_WORDS*32-1:0] window;
  logic [FUSE_AW-1:0]      base;
  logic [IDX_W-1:0]        last_acc;
  logic                    unused_top;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign base       = {req_addr[BYTE_AW-1:WIN_LG], {(WIN_LG - BPF_LG){1'b0}}};
  assign last_acc   = IDX_W'(req_len >> BPF_LG);
  assign unused_top = ^req_addr[WIN_LG-1:0];

  fuse_rd_regs #(
    .WIN_WORDS (WIN_WORDS),
    .BUS_AW    (BUS_AW)
  ) i_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_wen    (bus_wen),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .done_pulse (done_pulse),
    .window     (window),
    .start      (start),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .cur_len    (cur_len),
    .rd_adj     (rd_adj),
    .rd_str     (rd_str),
    .irq        (irq)
  );

  fuse_rd_seq #(
    .FUSE_AW (FUSE_AW),
    .ACC_MAX (ACC_MAX)
  ) i_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (start),
    .base_in     (base),
    .last_in     (last_acc),
    .adj_in      (rd_adj),
    .str_in      (rd_str),
    .busy        (busy),
    .fuse_addr   (fuse_addr),
    .fuse_strobe (fuse_strobe),
    .cap_valid   (cap_valid),
    .cap_idx     (cap_idx),
    .done_pulse  (done_pulse)
  );

  fuse_rd_capture #(
    .FUSE_W    (FUSE_W),
    .WIN_WORDS (WIN_WORDS)
  ) i_cap (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cap_valid  (cap_valid),
    .cap_idx    (cap_idx),
    .fuse_rdata (fuse_rdata),
    .done_pulse (done_pulse),
    .len        (cur_len),
    .window     (window)
  );

endmodule

// File: tb/test_fuse_rd_ctrl.sv
module test_fuse_rd_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wen;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [8:0]  fuse_addr;
  logic        fuse_strobe;
  logic [15:0] fuse_rdata = 16'h0000;
  logic        irq;

  int          checks = 0;
  int          errors = 0;
  logic [31:0] exp_win [8];

  always #10 clk = ~clk;

  fuse_rd_ctrl i_fuse_rd_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wen     (bus_wen),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .fuse_addr   (fuse_addr),
    .fuse_strobe (fuse_strobe),
    .fuse_rdata  (fuse_rdata),
    .irq         (irq)
  );

  function automatic logic [15:0] fword(input logic [8:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'd40503 + 32'd4660;
    return t[15:0];
  endfunction

  function automatic logic [7:0] fbyte(input logic [9:0] b);
    logic [15:0] w;
    w = fword(b[9:1]);
    return b[0] ? w[15:8] : w[7:0];
  endfunction

  // synchronous fuse array model
  always @(posedge clk) if (fuse_strobe) fuse_rdata <= fword(fuse_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 6'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic calc_window(input logic [9:0] sa, input logic [4:0] len);
    logic [9:0] base_b;
    base_b = {sa[9:5], 5'b0};
    for (int w = 0; w < 8; w++) begin
      for (int b = 0; b < 4; b++) begin
        int i;
        i = 4 * w + b;
        exp_win[w][8*b +: 8] = (i <= int'(len)) ? fbyte(base_b + 10'(i)) : 8'h00;
      end
    end
  endtask

  task automatic check_window(input string tag);
    logic [31:0] v;
    for (int w = 0; w < 8; w++) begin
      rd(12 + 4 * w, v);
      chk(v === exp_win[w], tag, v, exp_win[w]);
    end
  endtask

  // full transfer with per-cycle strobe/address/done checking
  task automatic run_xfer(input logic [9:0] sa, input logic [4:0] len, input int adj, input int str, input bit ie);
    int          t, n, bad;
    logic [31:0] v;
    logic [8:0]  base;
    t = adj + 5 + str;
    n = int'(len) / 2 + 1;
    bad = 0;
    base = {sa[9:5], 4'b0};
    wr(4, {ie, 7'b0, 4'(adj), 4'(str), 16'h0});
    wr(0, {1'b0, sa, len, 15'b0, 1'b1});
    for (int k = 0; k < n * t; k++) begin
      bit es;
      es = (k % t) > adj;
      rd(8, v);
      if (fuse_strobe !== es || fuse_addr !== base + 9'(k / t) || v[0] !== 1'b0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R3 R4 strobe/address per cycle", 32'(bad), 32'd0);
    rd(8, v);
    chk(v[1:0] == 2'b01, "R5 done after n*T cycles", v, 32'd1);
    rd(0, v);
    chk(v == {1'b0, sa, len, 16'b0}, "R5 read-enable self-clear", v, {1'b0, sa, len, 16'b0});
    chk(irq == ie, "R9 irq follows enable and done", 32'(irq), 32'(ie));
    calc_window(sa, len);
    check_window("R6 data packing");
    wr(8, 32'h1);
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_wen = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 44; a += 4) begin
      rd(a, v);
      chk(v == 32'h0, "R1 reset register", v, 32'h0);
    end
    chk(irq == 1'b0 && fuse_strobe == 1'b0, "R1 reset outputs", {irq, fuse_strobe}, 32'h0);

    // R2 field layout
    wr(4, 32'hFFFF_FFFF);
    rd(4, v);
    chk(v == 32'h80FF_FFFF, "R2 config mask", v, 32'h80FF_FFFF);
    wr(0, 32'hFFFF_FFFE);
    rd(0, v);
    chk(v == 32'h7FFF_8002, "R2 control layout", v, 32'h7FFF_8002);
    rd(8, v);
    chk(v == 32'h0, "R2 R8 status untouched", v, 32'h0);
    wr(4, 32'h0);

    // R8 write/program enable without read-enable
    begin
      int hits;
      hits = 0;
      wr(0, 32'h0020_8002);
      for (int k = 0; k < 40; k++) begin
        if (fuse_strobe) hits++;
        @(negedge clk);
      end
      chk(hits == 0, "R8 no strobe", 32'(hits), 32'd0);
      rd(0, v);
      chk(v == 32'h0020_8002, "R8 bits stored", v, 32'h0020_8002);
      rd(8, v);
      chk(v == 32'h0, "R8 status unchanged", v, 32'h0);
    end

    // main sweep over every adjust/strobe pair
    for (int adj = 0; adj < 16; adj++) begin
      for (int str = 0; str < 16; str++) begin
        run_xfer(10'((adj * 16 + str) * 37), 5'((adj * 3 + str * 5) % 32), adj, str, bit'((adj + str) % 2));
      end
    end

    // R9 write-one-to-clear and interrupt gating
    wr(4, 32'h8000_0000 | (32'd1 << 20) | (32'd2 << 16));
    wr(0, {1'b0, 10'd64, 5'd3, 16'h0001});
    repeat (30) @(negedge clk);
    chk(irq == 1'b1, "R9 irq set", 32'(irq), 32'd1);
    wr(0, 32'h0000_8000);
    rd(8, v);
    chk(v == 32'h1, "R8 pg-only keeps done", v, 32'h1);
    wr(8, 32'h0);
    rd(8, v);
    chk(v == 32'h1 && irq == 1'b1, "R9 write zero keeps done", v, 32'h1);
    wr(4, 32'h0);
    chk(irq == 1'b0, "R9 irq masked", 32'(irq), 32'd0);
    wr(8, 32'h1);
    rd(8, v);
    chk(v == 32'h0, "R9 write one clears", v, 32'h0);

    // R7 control write during a transfer
    run_xfer(10'd100, 5'd31, 0, 0, 1'b0);
    wr(4, (32'd2 << 20) | (32'd3 << 16));
    wr(0, {1'b0, 10'd512, 5'd31, 16'h0001});
    repeat (20) @(negedge clk);
    wr(0, {1'b0, 10'd900, 5'd4, 16'h0001});
    rd(0, v);
    chk(v[30:16] == {10'd512, 5'd31}, "R7 busy write ignored", v, {1'b0, 10'd512, 5'd31, 16'h0001});
    check_window("R7 data held mid-transfer");
    begin
      int waited;
      waited = 0;
      rd(8, v);
      while (v[0] == 1'b0 && waited < 400) begin
        @(negedge clk);
        waited++;
        rd(8, v);
      end
      chk(v[0] == 1'b1, "R7 transfer completes", v, 32'h1);
    end
    calc_window(10'd512, 5'd31);
    check_window("R7 data of first request");
    begin
      int hits;
      hits = 0;
      for (int k = 0; k < 40; k++) begin
        if (fuse_strobe) hits++;
        @(negedge clk);
      end
      chk(hits == 0, "R7 no queued start", 32'(hits), 32'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule